// File: doc/BRIEF.md
# Received-Frame Header Filter and Dispatcher

This block decides what happens to each frame waiting in an external Ethernet controller's receive buffer. When the idle controller hands it a start pulse, it pulls the frame one byte at a time through the controller's auto-read port. It counts from the first header byte and stops at the first two payload bytes. The first of these names the board slot the frame is meant for. The second is a private packet-type code that has nothing to do with the Ethernet type field.

A frame meant for another slot, or carrying an unknown type code, is dropped. The block writes the skip command into the controller's receive-control register and then hands control back to the idle controller. Reset and query frames carry nothing the logic needs, so they are also dropped, and then the matching handler is started. Soft-reset and programming frames stay in the buffer, and their handler is started while the rest of the frame is still unread. That handler drops the frame itself once it has finished.

Top module: `pkt_filter_dispatch`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every output request and every dispatch pulse is low.
- R2: Each byte fetch is a one-cycle `rd_req_o` pulse. The next pulse comes only after `rd_valid_i` has returned the previous byte, however long that takes.
- R3: Byte 15 (1-based, counted from the first header byte) is the slot location. The frame passes this test when the byte equals `loc_i` or equals 0xFF. On a mismatch the frame is skipped after exactly 15 fetches, and `to_idle_o` pulses.
- R4: Byte 16 is the type code. 0x52 (reset) and 0x51 (query) cause one skip write followed by a `go_reset_o` or `go_query_o` pulse. Such frames take exactly 16 fetches.
- R5: Type 0x53 (soft reset) and type 0x50 (programming) cause no skip write. They are dispatched on `go_soft_o` or `go_prog_o` after exactly 16 fetches.
- R6: Any other type code, including lowercase letters, causes a skip write followed by a `to_idle_o` pulse.
- R7: A skip is a single one-cycle `wr_req_o` with `wr_addr_o` = 0x11 and `wr_data_o` = 0x02. The pulse that follows waits for `wr_done_i`, however late it arrives.
- R8: Each frame ends in exactly one one-cycle pulse on exactly one of `to_idle_o`, `go_reset_o`, `go_query_o`, `go_soft_o` and `go_prog_o`. No further fetch is made until the next start.
- R9: A `start_i` pulse that arrives while a frame is being filtered has no effect.
- R10: Once a skip has been decided, no further byte fetch is made for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse from the idle controller |
| rd_req_o | output | 1 | Fetch-next-byte pulse to the auto-read port |
| rd_valid_i | input | 1 | Fetched byte is valid |
| rd_data_i | input | 8 | Fetched byte |
| wr_req_o | output | 1 | Register-write request pulse |
| wr_addr_o | output | 8 | Register address for the write |
| wr_data_o | output | 8 | Register value for the write |
| wr_done_i | input | 1 | Register write finished |
| loc_i | input | 8 | Hardwired slot location |
| to_idle_o | output | 1 | Return-to-idle pulse |
| go_reset_o | output | 1 | Start the reset handler |
| go_query_o | output | 1 | Start the query handler |
| go_soft_o | output | 1 | Start the soft-reset handler |
| go_prog_o | output | 1 | Start the programming handler |

## Verification
A wrong byte count shows up at the ports within a single frame. A count that is off by one makes the block read the location from the wrong byte, so a frame that should pass is skipped, or a frame that should be skipped passes. It also changes the number of fetch pulses away from exactly 15 or 16. A stale or wrongly decoded verdict shows as the wrong dispatch pulse, or as a skip write where none belongs (or none where one belongs), in the cycles just after byte 16. A stuck sequencer shows as a missing pulse, a second pulse, or fetches that continue after the verdict. Latency is varied on both the fetch and the write handshakes, so an early advance that ignores an acknowledge also produces a visible difference.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_FETCH,
        PS_FETCH_WAIT,
        PS_JUDGE,
        PS_SKIP,
        PS_SKIP_WAIT,
        PS_FINISH
    } pfd_state_e;

    typedef enum logic [2:0] {
        DEST_IDLE,
        DEST_RESET,
        DEST_QUERY,
        DEST_SOFT,
        DEST_PROG
    } pfd_dest_e;

    typedef struct packed {
        pfd_dest_e dest;
        logic      keep;
    } pfd_verdict_t;

endpackage

// File: rtl/pfd_field_latch.sv
module pfd_field_latch #(
    parameter int POS   = 15,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             stb,
    input  logic [CNT_W-1:0] idx,
    input  logic [7:0]       data,
    output logic [7:0]       field_o
);

    localparam logic [CNT_W-1:0] POS_C = CNT_W'(POS);

    logic [7:0] field_d;
    logic [7:0] field_q;

    always_comb begin
        field_d = field_q;
        if (clr) begin
            field_d = '0;
        end else if (stb && (idx == POS_C)) begin
            field_d = data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
        end else begin
            field_q <= field_d;
        end
    end

    assign field_o = field_q;

endmodule

// File: rtl/pfd_loc_match.sv
module pfd_loc_match #(
    parameter logic [7:0] BCAST_LOC = 8'hFF
) (
    input  logic [7:0] loc_field,
    input  logic [7:0] own_loc,
    output logic       match_o
);

    logic exact_hit;
    logic bcast_hit;

    always_comb begin
        exact_hit = (loc_field == own_loc);
        bcast_hit = (loc_field == BCAST_LOC);
        match_o   = exact_hit || bcast_hit;
    end

endmodule

// File: rtl/pfd_type_decode.sv
module pfd_type_decode
    import pfd_pkg::*;
#(
    parameter logic [7:0] CODE_RESET = 8'h52,
    parameter logic [7:0] CODE_QUERY = 8'h51,
    parameter logic [7:0] CODE_SOFT  = 8'h53,
    parameter logic [7:0] CODE_PROG  = 8'h50
) (
    input  logic [7:0]   code,
    output pfd_verdict_t verdict_o
);

    always_comb begin
        verdict_o.dest = DEST_IDLE;
        verdict_o.keep = 1'b0;
        unique case (code)
            CODE_RESET: verdict_o.dest = DEST_RESET;
            CODE_QUERY: verdict_o.dest = DEST_QUERY;
            CODE_SOFT: begin
                verdict_o.dest = DEST_SOFT;
                verdict_o.keep = 1'b1;
            end
            CODE_PROG: begin
                verdict_o.dest = DEST_PROG;
                verdict_o.keep = 1'b1;
            end
            default: begin
                verdict_o.dest = DEST_IDLE;
                verdict_o.keep = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pkt_filter_dispatch.sv
module pkt_filter_dispatch
    import pfd_pkg::*;
#(
    parameter int         LOC_POS    = 15,
    parameter int         TYPE_POS   = 16,
    parameter logic [7:0] BCAST_LOC  = 8'hFF,
    parameter logic [7:0] RXCTL_ADDR = 8'h11,
    parameter logic [7:0] SKIP_CMD   = 8'h02,
    parameter logic [7:0] CODE_RESET = 8'h52,
    parameter logic [7:0] CODE_QUERY = 8'h51,
    parameter logic [7:0] CODE_SOFT  = 8'h53,
    parameter logic [7:0] CODE_PROG  = 8'h50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    output logic       rd_req_o,
    input  logic       rd_valid_i,
    input  logic [7:0] rd_data_i,
    output logic       wr_req_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    input  logic       wr_done_i,
    input  logic [7:0] loc_i,
    output logic       to_idle_o,
    output logic       go_reset_o,
    output logic       go_query_o,
    output logic       go_soft_o,
    output logic       go_prog_o
);

    localparam int               CNT_W    = $clog2(TYPE_POS + 1);
    localparam logic [CNT_W-1:0] LOC_IDX  = CNT_W'(LOC_POS);
    localparam logic [CNT_W-1:0] TYPE_IDX = CNT_W'(TYPE_POS);

    typedef struct packed {
        pfd_state_e       st;
        logic [CNT_W-1:0] cnt;
        pfd_dest_e        dest;
        logic             at_type;
        logic [7:0]       waddr;
        logic [7:0]       wdata;
    } fsm_t;

    fsm_t fsm_d;
    fsm_t fsm_q;

    logic             byte_stb;
    logic [CNT_W-1:0] idx_next;
    logic [7:0]       loc_field;
    logic [7:0]       type_field;
    logic             loc_ok;
    logic             frame_clr;
    pfd_verdict_t     verdict;

    assign byte_stb  = (fsm_q.st == PS_FETCH_WAIT) && rd_valid_i;
    assign idx_next  = fsm_q.cnt + 1'b1;
    assign frame_clr = (fsm_q.st == PS_IDLE) && start_i;

    pfd_field_latch #(
        .POS   (LOC_POS),
        .CNT_W (CNT_W)
    ) i_loc_latch (
        .clk     (clk),
        .rst     (rst),
        .clr     (frame_clr),
        .stb     (byte_stb),
        .idx     (idx_next),
        .data    (rd_data_i),
        .field_o (loc_field)
    );

    pfd_field_latch #(
        .POS   (TYPE_POS),
        .CNT_W (CNT_W)
    ) i_type_latch (
        .clk     (clk),
        .rst     (rst),
        .clr     (frame_clr),
        .stb     (byte_stb),
        .idx     (idx_next),
        .data    (rd_data_i),
        .field_o (type_field)
    );

    pfd_loc_match #(
        .BCAST_LOC (BCAST_LOC)
    ) i_loc_match (
        .loc_field (loc_field),
        .own_loc   (loc_i),
        .match_o   (loc_ok)
    );

    pfd_type_decode #(
        .CODE_RESET (CODE_RESET),
        .CODE_QUERY (CODE_QUERY),
        .CODE_SOFT  (CODE_SOFT),
        .CODE_PROG  (CODE_PROG)
    ) i_type_decode (
        .code      (type_field),
        .verdict_o (verdict)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            PS_IDLE: begin
                if (start_i) begin
                    fsm_d.st      = PS_FETCH;
                    fsm_d.cnt     = '0;
                    fsm_d.dest    = DEST_IDLE;
                    fsm_d.at_type = 1'b0;
                end
            end
            PS_FETCH: begin
                fsm_d.st = PS_FETCH_WAIT;
            end
            PS_FETCH_WAIT: begin
                if (rd_valid_i) begin
                    fsm_d.cnt = idx_next;
                    if (idx_next == LOC_IDX) begin
                        fsm_d.st      = PS_JUDGE;
                        fsm_d.at_type = 1'b0;
                    end else if (idx_next == TYPE_IDX) begin
                        fsm_d.st      = PS_JUDGE;
                        fsm_d.at_type = 1'b1;
                    end else begin
                        fsm_d.st = PS_FETCH;
                    end
                end
            end
            PS_JUDGE: begin
                if (!fsm_q.at_type) begin
                    if (loc_ok) begin
                        fsm_d.st = PS_FETCH;
                    end else begin
                        fsm_d.st    = PS_SKIP;
                        fsm_d.dest  = DEST_IDLE;
                        fsm_d.waddr = RXCTL_ADDR;
                        fsm_d.wdata = SKIP_CMD;
                    end
                end else begin
                    fsm_d.dest = verdict.dest;
                    if (verdict.keep) begin
                        fsm_d.st = PS_FINISH;
                    end else begin
                        fsm_d.st    = PS_SKIP;
                        fsm_d.waddr = RXCTL_ADDR;
                        fsm_d.wdata = SKIP_CMD;
                    end
                end
            end
            PS_SKIP: begin
                fsm_d.st = PS_SKIP_WAIT;
            end
            PS_SKIP_WAIT: begin
                fsm_d.waddr = '0;
                fsm_d.wdata = '0;
                if (wr_done_i) begin
                    fsm_d.st = PS_FINISH;
                end
            end
            PS_FINISH: begin
                fsm_d.st  = PS_IDLE;
                fsm_d.cnt = '0;
            end
            default: begin
                fsm_d.st = PS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.st      <= PS_IDLE;
            fsm_q.cnt     <= '0;
            fsm_q.dest    <= DEST_IDLE;
            fsm_q.at_type <= 1'b0;
            fsm_q.waddr   <= '0;
            fsm_q.wdata   <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign rd_req_o   = (fsm_q.st == PS_FETCH);
    assign wr_req_o   = (fsm_q.st == PS_SKIP);
    assign wr_addr_o  = fsm_q.waddr;
    assign wr_data_o  = fsm_q.wdata;
    assign to_idle_o  = (fsm_q.st == PS_FINISH) && (fsm_q.dest == DEST_IDLE);
    assign go_reset_o = (fsm_q.st == PS_FINISH) && (fsm_q.dest == DEST_RESET);
    assign go_query_o = (fsm_q.st == PS_FINISH) && (fsm_q.dest == DEST_QUERY);
    assign go_soft_o  = (fsm_q.st == PS_FINISH) && (fsm_q.dest == DEST_SOFT);
    assign go_prog_o  = (fsm_q.st == PS_FINISH) && (fsm_q.dest == DEST_PROG);

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_req_o,
    input logic       rd_valid_i,
    input logic       wr_req_o,
    input logic       wr_done_i,
    input logic       to_idle_o,
    input logic       go_reset_o,
    input logic       go_query_o,
    input logic       go_soft_o,
    input logic       go_prog_o
);

    logic [4:0] term_vec;
    logic       any_term;
    logic       rd_out_q;
    logic       wr_wait_q;
    logic       skip_seen_q;

    assign term_vec = {to_idle_o, go_reset_o, go_query_o, go_soft_o, go_prog_o};
    assign any_term = |term_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_out_q    <= 1'b0;
            wr_wait_q   <= 1'b0;
            skip_seen_q <= 1'b0;
        end else begin
            if (rd_req_o)        rd_out_q <= 1'b1;
            else if (rd_valid_i) rd_out_q <= 1'b0;
            if (wr_req_o)        wr_wait_q <= 1'b1;
            else if (wr_done_i)  wr_wait_q <= 1'b0;
            if (wr_req_o)        skip_seen_q <= 1'b1;
            else if (any_term)   skip_seen_q <= 1'b0;
        end
    end

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst) rd_req_o |=> !rd_req_o); // R2
    AST_RD_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst) !(rd_req_o && rd_out_q)); // R2
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) wr_req_o |=> !wr_req_o); // R7
    AST_TERM_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) !(any_term && wr_wait_q)); // R7
    AST_TERM_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(term_vec)); // R8
    AST_TERM_PULSE: assert property (@(posedge clk) disable iff (rst) any_term |=> !any_term); // R8
    AST_NO_READ_AFTER_SKIP: assert property (@(posedge clk) disable iff (rst) !(rd_req_o && skip_seen_q)); // R10
    AST_KEEP_NO_SKIP: assert property (@(posedge clk) disable iff (rst) (go_soft_o || go_prog_o) |-> !skip_seen_q); // R5
    AST_DROP_HAS_SKIP: assert property (@(posedge clk) disable iff (rst) (to_idle_o || go_reset_o || go_query_o) |-> skip_seen_q); // R4

endmodule

bind pkt_filter_dispatch pfd_checker i_pfd_checker (
    .clk        (clk),
    .rst        (rst),
    .rd_req_o   (rd_req_o),
    .rd_valid_i (rd_valid_i),
    .wr_req_o   (wr_req_o),
    .wr_done_i  (wr_done_i),
    .to_idle_o  (to_idle_o),
    .go_reset_o (go_reset_o),
    .go_query_o (go_query_o),
    .go_soft_o  (go_soft_o),
    .go_prog_o  (go_prog_o)
);

// File: tb/test_pkt_filter_dispatch.sv
`timescale 1ns/1ps
module test_pkt_filter_dispatch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       rd_req_o;
    logic       rd_valid_i = 1'b0;
    logic [7:0] rd_data_i = 8'h00;
    logic       wr_req_o;
    logic [7:0] wr_addr_o;
    logic [7:0] wr_data_o;
    logic       wr_done_i = 1'b0;
    logic [7:0] loc_i = 8'h27;
    logic       to_idle_o, go_reset_o, go_query_o, go_soft_o, go_prog_o;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] frame [0:31];
    int  rd_lat = 1, wr_lat = 1, rd_wait = 0, wr_wait = 0;
    int  n_reads = 0, n_writes = 0, n_term = 0;
    int  n_idle = 0, n_rst = 0, n_qry = 0, n_soft = 0, n_prog = 0;
    logic [7:0] last_addr = 8'h00, last_data = 8'h00;
    int  cyc = 0, done_cyc = 0, pulse_cyc = 0;
    bit  inject_busy = 1'b0, start_clr = 1'b0;

    always #10 clk = ~clk;

    pkt_filter_dispatch i_pkt_filter_dispatch (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .rd_req_o   (rd_req_o),
        .rd_valid_i (rd_valid_i),
        .rd_data_i  (rd_data_i),
        .wr_req_o   (wr_req_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_done_i  (wr_done_i),
        .loc_i      (loc_i),
        .to_idle_o  (to_idle_o),
        .go_reset_o (go_reset_o),
        .go_query_o (go_query_o),
        .go_soft_o  (go_soft_o),
        .go_prog_o  (go_prog_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // controller model: answers fetches and register writes, watches pulses
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            rd_valid_i = 1'b0;
            wr_done_i  = 1'b0;
            if (start_clr) begin
                start_i   = 1'b0;
                start_clr = 1'b0;
            end
            if (rd_wait > 0) begin
                rd_wait--;
                if (rd_wait == 0) begin
                    rd_valid_i = 1'b1;
                    rd_data_i  = frame[n_reads % 32];
                    n_reads++;
                    if (inject_busy && n_reads == 5) begin
                        start_i   = 1'b1;
                        start_clr = 1'b1;
                    end
                end
            end
            if (rd_req_o) rd_wait = rd_lat;
            if (wr_wait > 0) begin
                wr_wait--;
                if (wr_wait == 0) begin
                    wr_done_i = 1'b1;
                    done_cyc  = cyc;
                end
            end
            if (wr_req_o) begin
                n_writes++;
                last_addr = wr_addr_o;
                last_data = wr_data_o;
                wr_wait   = wr_lat;
            end
            if (to_idle_o)  n_idle++;
            if (go_reset_o) n_rst++;
            if (go_query_o) n_qry++;
            if (go_soft_o)  n_soft++;
            if (go_prog_o)  n_prog++;
            if (to_idle_o || go_reset_o || go_query_o || go_soft_o || go_prog_o) begin
                n_term++;
                pulse_cyc = cyc;
            end
        end
    end

    // dest: 0 idle, 1 reset, 2 query, 3 soft, 4 prog
    task automatic run_frame(input string tag, input logic [7:0] loc_b,
                             input logic [7:0] type_b, input int exp_reads,
                             input int exp_writes, input int dest);
        int guard;
        int got;
        for (int i = 0; i < 32; i++) frame[i] = 8'(8'hA0 + i);
        frame[LOCB] = loc_b;
        frame[TYPEB] = type_b;
        @(negedge clk);
        n_reads = 0; n_writes = 0; n_term = 0;
        n_idle = 0; n_rst = 0; n_qry = 0; n_soft = 0; n_prog = 0;
        last_addr = 8'h00; last_data = 8'h00;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (n_term == 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        check(n_term != 0, tag, "frame finished", n_term, 1);
        repeat (8) @(negedge clk);
        check(n_reads == exp_reads, tag, "byte fetches", n_reads, exp_reads);
        check(n_writes == exp_writes, tag, "skip writes", n_writes, exp_writes);
        if (exp_writes != 0) begin
            check(last_addr == 8'h11, "R7", "skip address", last_addr, 8'h11);
            check(last_data == 8'h02, "R7", "skip value", last_data, 8'h02);
        end
        check(n_term == 1, "R8", "single end pulse", n_term, 1);
        case (dest)
            0: got = n_idle;
            1: got = n_rst;
            2: got = n_qry;
            3: got = n_soft;
            default: got = n_prog;
        endcase
        check(got == 1, tag, "selected output", got, 1);
    endtask

    localparam int LOCB  = 14;
    localparam int TYPEB = 15;

    task automatic t_reset_state();
        check(!rd_req_o && !wr_req_o, "R1", "requests in reset", rd_req_o + wr_req_o, 0);
        check(!(to_idle_o | go_reset_o | go_query_o | go_soft_o | go_prog_o), "R1",
              "pulses in reset", 1, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!rd_req_o && !wr_req_o && !to_idle_o, "R1", "outputs after reset", rd_req_o, 0);
    endtask

    task automatic t_reset_frame();   run_frame("R4", 8'h27, 8'h52, 16, 1, 1); endtask
    task automatic t_bcast_query();   run_frame("R3", 8'hFF, 8'h51, 16, 1, 2); endtask
    task automatic t_soft_keep();     run_frame("R5", 8'h27, 8'h53, 16, 0, 3); endtask
    task automatic t_prog_slow_read();
        rd_lat = 4;
        run_frame("R2", 8'h27, 8'h50, 16, 0, 4);
        rd_lat = 1;
    endtask
    task automatic t_wrong_slot();    run_frame("R10", 8'h28, 8'h52, 15, 1, 0); endtask
    task automatic t_bad_type();      run_frame("R6", 8'h27, 8'h41, 16, 1, 0); endtask
    task automatic t_lower_type();    run_frame("R6", 8'hFF, 8'h72, 16, 1, 0); endtask
    task automatic t_slow_write();
        wr_lat = 6;
        run_frame("R7", 8'h27, 8'h51, 16, 1, 2);
        check(pulse_cyc > done_cyc, "R7", "pulse after write done", pulse_cyc, done_cyc + 1);
        wr_lat = 1;
    endtask
    task automatic t_busy_start();
        inject_busy = 1'b1;
        run_frame("R9", 8'h27, 8'h53, 16, 0, 3);
        inject_busy = 1'b0;
    endtask
    task automatic t_mismatch_idle();
        loc_i = 8'h05;
        run_frame("R3", 8'h27, 8'h50, 15, 1, 0);
        loc_i = 8'h27;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_reset_frame();
        t_bcast_query();
        t_soft_keep();
        t_prog_slow_read();
        t_wrong_slot();
        t_bad_type();
        t_lower_type();
        t_slow_write();
        t_busy_start();
        t_mismatch_idle();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule